// File: doc/BRIEF.md
# Spread-Spectrum Phase-Rotation Modulator

This block produces the digital control for a multiphase fractional-N spread-spectrum clock source. It runs on a fast clock at three times the reference rate and derives the reference-period boundary internally with a divide-by-three phase counter. A triangle generator walks an index up from zero to a half-period length and back down, one step per reference period. The index is scaled by a configurable slope to form a frequency-offset word. Zero offset stands for the nominal frequency at the top of the triangle, and the largest offset stands for the bottom of the down-spread.

A third-order multi-stage noise-shaping modulator, built as three cascaded first-order accumulators with error cancellation, turns the offset word into an integer phase step on every fast clock. Three consecutive steps are summed into one count per reference period. That count is added, modulo ten, to a phase-select pointer that drives a ten-input phase multiplexer in front of the feedback divider. One pointer step is a tenth of a unit interval. With a divide ratio of 60, a full-scale word of one step per fast sample (three per reference period) gives about 5000 ppm of down-spread. With enable low the block is in unspread mode: the modulator is cleared and the pointer stays where it is.

Top module: `ssc_phase_rotator`

## Requirements
- R1: After reset, phase_sel, step_cnt and profile are all zero.
- R2: The triangle index starts at 0 rising, and changes by one on the last fast cycle of each reference period (fast cycles are numbered 0,1,2 from reset, and the last is number 2). It reaches HALF_LEN and then falls back to 0, so one full triangle lasts 2*HALF_LEN reference periods. profile equals min(index*depth, 2^FRAC_W-1) as an unsigned value.
- R3: On every fast cycle the modulator takes profile/2^FRAC_W as its input and emits c1 + (c2 - c2') + (c3 - 2*c3' + c3''). Here c1, c2, c3 are the carries of the three cascaded accumulators, and a prime marks one fast cycle of delay. step_cnt is a two's-complement value equal to the sum of the modulator outputs over the three fast cycles of a reference period. It updates only at the end of that period and stays within -9 to +12.
- R4: phase_sel updates only at the end of a reference period, to (old phase_sel + step_cnt) mod 10. It always lies in 0 to 9.
- R5: While spread_en is low, all three modulator stages, their delayed carries and the partial sum are cleared, and the triangle returns to index 0 rising. From the next clock, step_cnt reads 0, profile reads 0 and phase_sel holds its value.
- R6: Over one full triangle period that starts from the cleared state at the first fast cycle of a reference period, the sum of step_cnt differs from the ideal area (the sum of profile/2^FRAC_W over all fast cycles) by less than 4 steps.
- R7: With a slope large enough that index*depth exceeds 2^FRAC_W-1, profile saturates at 2^FRAC_W-1.
- R8: With depth 0, step_cnt stays 0 and phase_sel never moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Modulator clock, three times the reference rate |
| rst_n | input | 1 | Active-low synchronous reset |
| spread_en | input | 1 | 1 = spreading active, 0 = unspread mode |
| depth | input | DEPTH_W (8) | Triangle slope: offset-word increment per index step |
| phase_sel | output | PH_W (4) | Phase-multiplexer select, 0 to 9 |
| step_cnt | output | STEP_W (5) | Signed phase steps applied in the last reference period |
| profile | output | FRAC_W (16) | Current frequency-offset word fed to the modulator |

## Verification
The hardest situation to reach from the ports is a reference period whose three fast samples are split by an enable edge. Such a period produces a partial sum and has to leave the pointer untouched until the following boundary. The bench raises enable at fast cycles 1 and 0 within the reference period. It runs whole triangles so that the pointer wraps both ways and the saturated bottom of the triangle is reached. A behavioural integer model tracks every fast cycle, and the long-run area check catches a modulator whose noise shaping does not cancel.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic {SLOPE_DOWN = 1'b0, SLOPE_UP = 1'b1} slope_e;

  // Pointer advance on a ring of n positions; d may be negative.
  function automatic int wrap_phase(int p, int d, int n);
    int r;
    r = (p + d) % n;
    if (r < 0) r = r + n;
    return r;
  endfunction
endpackage

// File: rtl/ssc_ref_phase.sv
module ssc_ref_phase #(
  parameter int OSR = 3,
  localparam int PHC_W = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PHC_W-1:0] phase_q,
  output logic             tick
);
  always_ff @(posedge clk) begin
    if (!rst_n)                               phase_q <= '0;
    else if (phase_q == PHC_W'(OSR - 1))      phase_q <= '0;
    else                                      phase_q <= phase_q + 1'b1;
  end

  assign tick = (phase_q == PHC_W'(OSR - 1));
endmodule

// File: rtl/ssc_tri_profile.sv
module ssc_tri_profile
  import ssc_pkg::*;
#(
  parameter int HALF_LEN = 333,
  parameter int FRAC_W   = 16,
  parameter int DEPTH_W  = 8,
  localparam int IDX_W  = $clog2(HALF_LEN + 1),
  localparam int PROD_W = IDX_W + DEPTH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic [DEPTH_W-1:0] depth,
  output logic [IDX_W-1:0]   tri_idx,
  output logic [FRAC_W-1:0]  profile
);
  slope_e             slope_q;
  logic [PROD_W-1:0]  prod;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      tri_idx <= '0;
      slope_q <= SLOPE_UP;
    end else if (tick) begin
      if (slope_q == SLOPE_UP) begin
        tri_idx <= tri_idx + 1'b1;
        if (tri_idx == IDX_W'(HALF_LEN - 1)) slope_q <= SLOPE_DOWN;
      end else begin
        tri_idx <= tri_idx - 1'b1;
        if (tri_idx == IDX_W'(1)) slope_q <= SLOPE_UP;
      end
    end
  end

  assign prod = PROD_W'(tri_idx) * PROD_W'(depth);

  generate
    if (PROD_W > FRAC_W) begin : g_sat
      localparam logic [PROD_W-1:0] FULL = PROD_W'({FRAC_W{1'b1}});
      assign profile = (prod > FULL) ? {FRAC_W{1'b1}} : prod[FRAC_W-1:0];
    end else begin : g_nosat
      assign profile = FRAC_W'(prod);
    end
  endgenerate
endmodule

// File: rtl/ssc_mash111.sv
module ssc_mash111 #(
  parameter int FRAC_W = 16,
  localparam int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [FRAC_W-1:0] frac_in,
  output logic signed [3:0] dout
);
  logic [FRAC_W-1:0] stage_in  [STAGES];
  logic [FRAC_W-1:0] resid     [STAGES];
  logic [FRAC_W-1:0] resid_q   [STAGES];
  logic [STAGES-1:0] carry;
  logic              c2_d1, c3_d1, c3_d2;

  assign stage_in[0] = frac_in;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [FRAC_W:0] total;
      assign total    = {1'b0, resid_q[s]} + {1'b0, stage_in[s]};
      assign carry[s] = total[FRAC_W];
      assign resid[s] = total[FRAC_W-1:0];
      if (s + 1 < STAGES) begin : g_chain
        assign stage_in[s+1] = resid[s];
      end
      always_ff @(posedge clk) begin
        if (!rst_n || clr) resid_q[s] <= '0;
        else               resid_q[s] <= resid[s];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else begin
      c2_d1 <= carry[1];
      c3_d1 <= carry[2];
      c3_d2 <= c3_d1;
    end
  end

  // First stage plus first and second differences of the later carries.
  assign dout = 4'({3'b0, carry[0]} + {3'b0, carry[1]} - {3'b0, c2_d1}
                 + {3'b0, carry[2]} - {2'b0, c3_d1, 1'b0} + {3'b0, c3_d2});
endmodule

// File: rtl/ssc_phase_accum.sv
module ssc_phase_accum #(
  parameter int PHASES = 10,
  parameter int OSR    = 3,
  localparam int PH_W   = $clog2(PHASES),
  localparam int STEP_W = $clog2(4 * OSR + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     tick,
  input  logic signed [3:0]        sample,
  output logic signed [STEP_W-1:0] step_q,
  output logic [PH_W-1:0]          ptr_q
);
  logic signed [STEP_W-1:0] part_q;
  logic signed [STEP_W-1:0] total;
  logic [PH_W-1:0]          ptr_nxt;

  assign total   = part_q + {{(STEP_W-4){sample[3]}}, sample};
  assign ptr_nxt = PH_W'(ssc_pkg::wrap_phase(int'(ptr_q), int'(total), PHASES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q <= '0;
      step_q <= '0;
      ptr_q  <= '0;
    end else if (clr) begin
      part_q <= '0;
      step_q <= '0;
    end else if (tick) begin
      part_q <= '0;
      step_q <= total;
      ptr_q  <= ptr_nxt;
    end else begin
      part_q <= total;
    end
  end
endmodule

// File: rtl/ssc_phase_rotator.sv
module ssc_phase_rotator #(
  parameter int PHASES   = 10,
  parameter int OSR      = 3,
  parameter int HALF_LEN = 333,
  parameter int FRAC_W   = 16,
  parameter int DEPTH_W  = 8,
  localparam int PH_W   = $clog2(PHASES),
  localparam int STEP_W = $clog2(4 * OSR + 1) + 1,
  localparam int IDX_W  = $clog2(HALF_LEN + 1),
  localparam int PHC_W  = (OSR > 1) ? $clog2(OSR) : 1
) (
  input  logic                     clk_fast,
  input  logic                     rst_n,
  input  logic                     spread_en,
  input  logic [DEPTH_W-1:0]       depth,
  output logic [PH_W-1:0]          phase_sel,
  output logic signed [STEP_W-1:0] step_cnt,
  output logic [FRAC_W-1:0]        profile
);
  logic [PHC_W-1:0]  ref_phase;
  logic              tick;
  logic [IDX_W-1:0]  tri_idx;
  logic signed [3:0] mod_out;

  ssc_ref_phase #(.OSR(OSR)) u_ref (
    .clk(clk_fast), .rst_n(rst_n), .phase_q(ref_phase), .tick(tick)
  );

  ssc_tri_profile #(.HALF_LEN(HALF_LEN), .FRAC_W(FRAC_W), .DEPTH_W(DEPTH_W)) u_tri (
    .clk(clk_fast), .rst_n(rst_n), .en(spread_en), .tick(tick),
    .depth(depth), .tri_idx(tri_idx), .profile(profile)
  );

  ssc_mash111 #(.FRAC_W(FRAC_W)) u_mash (
    .clk(clk_fast), .rst_n(rst_n), .clr(!spread_en),
    .frac_in(profile), .dout(mod_out)
  );

  ssc_phase_accum #(.PHASES(PHASES), .OSR(OSR)) u_acc (
    .clk(clk_fast), .rst_n(rst_n), .clr(!spread_en), .tick(tick),
    .sample(mod_out), .step_q(step_cnt), .ptr_q(phase_sel)
  );
endmodule

// File: rtl/ssc_phase_rotator_chk.sv
module ssc_phase_rotator_chk #(
  parameter int PHASES   = 10,
  parameter int OSR      = 3,
  parameter int HALF_LEN = 333,
  localparam int PH_W   = $clog2(PHASES),
  localparam int STEP_W = $clog2(4 * OSR + 1) + 1,
  localparam int IDX_W  = $clog2(HALF_LEN + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic                     tick,
  input logic [IDX_W-1:0]         tri_idx,
  input logic [PH_W-1:0]          phase_sel,
  input logic signed [STEP_W-1:0] step_cnt
);
  logic seen_clk;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_clk <= 1'b0;
    else        seen_clk <= 1'b1;
  end

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase_sel) < PHASES);

  p_ptr_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && phase_sel != $past(phase_sel)) |-> ($past(tick) && $past(en)));

  p_ptr_adds_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && $past(tick) && $past(en)) |->
      int'(phase_sel) == ssc_pkg::wrap_phase(int'($past(phase_sel)), int'(step_cnt), PHASES));

  p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(step_cnt) >= -3 * OSR) && (int'(step_cnt) <= 4 * OSR));

  p_step_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && $past(en) && !$past(tick)) |-> $stable(step_cnt));

  p_unspread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && !$past(en)) |-> (step_cnt == '0 && $stable(phase_sel) && tri_idx == '0));

  p_tri_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tri_idx) <= HALF_LEN);

  p_tri_unit_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_clk && $past(en) && $past(tick)) |->
      (int'(tri_idx) == int'($past(tri_idx)) + 1 || int'(tri_idx) + 1 == int'($past(tri_idx))));
endmodule

bind ssc_phase_rotator ssc_phase_rotator_chk i_chk (
  .clk(clk_fast), .rst_n(rst_n), .en(spread_en), .tick(tick),
  .tri_idx(tri_idx), .phase_sel(phase_sel), .step_cnt(step_cnt)
);

// File: tb/test_ssc_phase_rotator.sv
module test_ssc_phase_rotator;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 333;
  localparam int FULL  = 65535;
  localparam int SCALE = 65536;

  logic              clk_fast = 1'b0;
  logic              rst_n = 1'b0;
  logic              spread_en = 1'b0;
  logic [7:0]        depth = 8'd0;
  logic [3:0]        phase_sel;
  logic signed [4:0] step_cnt;
  logic [15:0]       profile;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_ph, m_t, m_up, m_e1, m_e2, m_e3, m_c2d, m_c3d, m_c3dd, m_acc, m_step, m_ptr;
  int grp_sum, grp_cnt, max_prof, nonzero_steps;
  real ideal;

  ssc_phase_rotator i_ssc_phase_rotator (
    .clk_fast(clk_fast), .rst_n(rst_n), .spread_en(spread_en), .depth(depth),
    .phase_sel(phase_sel), .step_cnt(step_cnt), .profile(profile)
  );

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_prof();
    int p = m_t * int'(depth);
    return (p > FULL) ? FULL : p;
  endfunction

  task automatic model_clear(input bit full);
    m_t = 0; m_up = 1; m_e1 = 0; m_e2 = 0; m_e3 = 0;
    m_c2d = 0; m_c3d = 0; m_c3dd = 0; m_acc = 0; m_step = 0;
    if (full) begin m_ptr = 0; m_ph = 0; end
  endtask

  // Advance the model across one rising edge using the held inputs.
  task automatic model_step();
    int x, a, c1, c2, c3, y;
    bit last;
    last = (m_ph == 2);
    if (!rst_n) model_clear(1'b1);
    else begin
      if (!spread_en) model_clear(1'b0);
      else begin
        x = m_prof();
        ideal += real'(x) / real'(SCALE);
        a = m_e1 + x;  c1 = a / SCALE;  m_e1 = a % SCALE;
        a = m_e2 + m_e1; c2 = a / SCALE; m_e2 = a % SCALE;
        a = m_e3 + m_e2; c3 = a / SCALE; m_e3 = a % SCALE;
        y = c1 + c2 - m_c2d + c3 - 2 * m_c3d + m_c3dd;
        m_c3dd = m_c3d; m_c3d = c3; m_c2d = c2;
        if (last) begin
          m_step = m_acc + y;
          m_ptr = ((m_ptr + m_step) % 10 + 10) % 10;
          m_acc = 0;
          grp_sum += m_step; grp_cnt++;
          if (m_step != 0) nonzero_steps++;
          if (m_up == 1) begin m_t++; if (m_t == HALF) m_up = 0; end
          else begin m_t--; if (m_t == 0) m_up = 1; end
        end else m_acc += y;
      end
      m_ph = last ? 0 : m_ph + 1;
    end
  endtask

  task automatic compare();
    check(int'(profile) == m_prof(), "R2 profile", int'(profile), m_prof());
    check(int'(step_cnt) == m_step, "R3 step_cnt", int'(step_cnt), m_step);
    check(int'(phase_sel) == m_ptr, "R4 phase_sel", int'(phase_sel), m_ptr);
    check(int'(phase_sel) <= 9, "R4 pointer range", int'(phase_sel), 9);
    if (int'(profile) > max_prof) max_prof = int'(profile);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_fast);
      model_step();
      @(negedge clk_fast);
      compare();
    end
  endtask

  task automatic align(input int ph);
    while (m_ph != ph) run(1);
  endtask

  task automatic clear_stats();
    grp_sum = 0; grp_cnt = 0; ideal = 0.0; max_prof = 0; nonzero_steps = 0;
  endtask

  initial begin
    int held;
    real err;
    model_clear(1'b1);
    clear_stats();
    run(4);
    // R1: reset values
    check(phase_sel == 0, "R1 reset phase_sel", int'(phase_sel), 0);
    check(step_cnt == 0, "R1 reset step_cnt", int'(step_cnt), 0);
    check(profile == 0, "R1 reset profile", int'(profile), 0);
    rst_n = 1'b1;
    run(5);

    // R6, R2: one full triangle from the cleared state, aligned to a period
    depth = 8'd196;
    align(0);
    spread_en = 1'b1;
    clear_stats();
    run(3 * 2 * HALF);
    err = real'(grp_sum) - ideal;
    check(grp_cnt == 2 * HALF, "R6 group count", grp_cnt, 2 * HALF);
    check(err < 4.0 && err > -4.0, "R6 area error", int'(err), 0);
    check(max_prof == HALF * 196, "R2 triangle peak", max_prof, HALF * 196);
    check(profile == 0, "R2 triangle back at top", int'(profile), 0);
    run(3 * HALF);

    // R5: unspread mode holds pointer and clears step and profile
    held = int'(phase_sel);
    spread_en = 1'b0;
    clear_stats();
    run(40);
    check(int'(phase_sel) == held, "R5 pointer held", int'(phase_sel), held);
    check(step_cnt == 0, "R5 step cleared", int'(step_cnt), 0);
    check(profile == 0, "R5 profile cleared", int'(profile), 0);
    check(grp_cnt == 0, "R5 no updates", grp_cnt, 0);

    // R7 with a mid-period enable: saturation at the bottom of the triangle
    depth = 8'd255;
    align(1);
    spread_en = 1'b1;
    clear_stats();
    run(3 * 2 * HALF + 1);
    check(max_prof == FULL, "R7 saturated profile", max_prof, FULL);

    // R3: small slope, enable at period start again
    spread_en = 1'b0;
    run(6);
    depth = 8'd3;
    align(0);
    spread_en = 1'b1;
    clear_stats();
    run(3 * HALF);
    check(grp_sum > 0, "R3 small slope produces steps", grp_sum, 1);

    // R8: zero slope never moves the pointer
    spread_en = 1'b0;
    run(3);
    depth = 8'd0;
    held = int'(phase_sel);
    spread_en = 1'b1;
    clear_stats();
    run(3 * 200);
    check(nonzero_steps == 0, "R8 zero steps", nonzero_steps, 0);
    check(int'(phase_sel) == held, "R8 pointer fixed", int'(phase_sel), held);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule